// File: doc/BRIEF.md
# Prioritized UART interrupt identifier

This block holds the interrupt-enable state of a 16550-style serial port and turns four pending conditions (receive overrun, receive data present, transmit holding register empty, modem status delta) into a single interrupt request line and an identification byte. Only the highest-priority enabled condition is reported. The block owns the enable register, the pending flag for transmit-empty, and the overrun flag with the line status read logic. Divisor latches, FIFO storage and the serial data paths sit elsewhere and reach this block as flags.

A host reaches the block through a single-cycle register port. Read data is valid combinationally in the access cycle. Read side effects take hold at the clock edge that ends that cycle. Two reads have side effects: reading the identification register drops a transmit-empty source when that source is the one it reports, and reading line status clears the overrun flag. The request line is a combinational function of the held state and the input flags, so it follows every access and every change of the receive flag in the cycle after the edge.

Top module: `uart_irq_ident`

## Requirements
- R1: The reported source follows a fixed priority. Line status (overrun flag with IER bit 2) is highest. Receive data present (with IER bit 0) comes next, then transmit-empty pending (with IER bit 1), then modem delta (with IER bit 3). If none of these applies, the result is "none pending".
- R2: The identification byte at offset 2 carries its code in bits 3:0. The codes are 0x6 for line status, 0xC for receive data, 0x2 for transmit empty, 0x0 for modem status and 0x1 for none pending. Bits 5:4 read as zero.
- R3: A write to offset 1 keeps bits 3:0 of the written byte as the enable value. A read of offset 1 returns that value with bits 7:4 zero.
- R4: Every write to offset 0 sets the transmit-empty pending flag.
- R5: A read of offset 2 clears the transmit-empty pending flag only when transmit-empty is the source it reports. Otherwise the flag is left as it was.
- R6: Bits 7:6 of the identification byte are both one when fifo_en is high and both zero when it is low.
- R7: A read of offset 5 returns bit 0 = rx_avail, bit 1 = overrun flag, bits 6 and 5 = 1, and all other bits 0. The overrun flag is cleared after the read.
- R8: irq is high exactly when the reported code is not "none pending".
- R9: Writes to offset 5 and offset 2 change none of the block's state.
- R10: A pulse on ovr_set sets the overrun flag. If that pulse comes in the same cycle as a line status read, the flag stays set.
- R11: After reset the enable value, the pending flag and the overrun flag are zero, and irq is low. Reads of offsets other than 1, 2 and 5 return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 3 | Register offset |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid during a read cycle, zero otherwise |
| ovr_set | input | 1 | Receive overrun event pulse |
| rx_avail | input | 1 | Receive FIFO holds at least one byte |
| fifo_en | input | 1 | FIFO mode enabled |
| modem_delta | input | 1 | Any modem status delta bit set |
| irq | output | 1 | Interrupt request |

## Verification
The state that is hardest to reach is a port where all four sources are pending at once and are masked in every combination. Only then can a read of the identification register be seen to leave the transmit-empty flag alone while a higher source hides it. The stimulus builds each of the 256 combinations of enable value and source flags from reset. It sets the transmit-empty flag with a data write and the overrun flag with a pulse. Then it reads the identification register twice, so the second read shows whether the first one cleared anything. The last cases are a line status read in the same cycle as a new overrun pulse, and writes to the read-only offsets.

// File: rtl/uart_irq_ident.sv
module uart_irq_ident #(
  parameter logic [2:0] OFS_DATA = 3'd0,
  parameter logic [2:0] OFS_IER  = 3'd1,
  parameter logic [2:0] OFS_IIR  = 3'd2,
  parameter logic [2:0] OFS_LSR  = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic [2:0] acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic       ovr_set,
  input  logic       rx_avail,
  input  logic       fifo_en,
  input  logic       modem_delta,
  output logic       irq
);
  localparam logic [3:0] CODE_LINE = 4'h6;
  localparam logic [3:0] CODE_RX   = 4'hC;
  localparam logic [3:0] CODE_TX   = 4'h2;
  localparam logic [3:0] CODE_MDM  = 4'h0;
  localparam logic [3:0] CODE_NONE = 4'h1;

  logic [3:0] ier_q;
  logic       thre_q;
  logic       ovr_q;
  logic [3:0] code;

  wire rd = acc_valid & ~acc_write;
  wire wr = acc_valid & acc_write;
  wire rd_iir = rd & (acc_addr == OFS_IIR);
  wire rd_lsr = rd & (acc_addr == OFS_LSR);

  always_comb begin
    if (ovr_q & ier_q[2])            code = CODE_LINE;
    else if (rx_avail & ier_q[0])    code = CODE_RX;
    else if (thre_q & ier_q[1])      code = CODE_TX;
    else if (modem_delta & ier_q[3]) code = CODE_MDM;
    else                             code = CODE_NONE;
  end

  assign irq = (code != CODE_NONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ier_q  <= '0;
      thre_q <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (wr && acc_addr == OFS_IER) ier_q <= acc_wdata[3:0];
      if (wr && acc_addr == OFS_DATA) thre_q <= 1'b1;
      else if (rd_iir && code == CODE_TX) thre_q <= 1'b0;
      if (ovr_set) ovr_q <= 1'b1;
      else if (rd_lsr) ovr_q <= 1'b0;
    end
  end

  always_comb begin
    acc_rdata = 8'h00;
    if (rd) begin
      case (acc_addr)
        OFS_IER: acc_rdata = {4'h0, ier_q};
        OFS_IIR: acc_rdata = {{2{fifo_en}}, 2'b00, code};
        OFS_LSR: acc_rdata = {1'b0, 2'b11, 3'b000, ovr_q, rx_avail};
        default: acc_rdata = 8'hFF;
      endcase
    end
  end

  assert_ier_upper_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && acc_addr == OFS_IER) |-> acc_rdata[7:4] == 4'h0);
  assert_thre_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && acc_addr == OFS_DATA) |=> thre_q);
  assert_thre_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_iir && acc_rdata[3:0] == CODE_TX) |=> !thre_q);
  assert_lsr_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lsr |-> acc_rdata[6:5] == 2'b11);
  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_lsr && !ovr_set) |=> !ovr_q);
  assert_ovr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_set |=> ovr_q);
  assert_irq_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ier_q != 4'h0));
endmodule

// File: tb/uart_irq_ident_tb.sv
module uart_irq_ident_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [2:0] acc_addr = '0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] acc_rdata;
  logic ovr_set = 1'b0, rx_avail = 1'b0, fifo_en = 1'b0, modem_delta = 1'b0;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_ident u_dut (.clk(clk), .rst_n(rst_n), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .ovr_set(ovr_set), .rx_avail(rx_avail),
    .fifo_en(fifo_en), .modem_delta(modem_delta), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0; acc_write = 0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a;
    #1 d = acc_rdata;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic pulse_ovr();
    @(negedge clk); ovr_set = 1;
    @(negedge clk); ovr_set = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  function automatic logic [3:0] exp_code(input logic [3:0] ie, input logic ov,
      input logic rx, input logic th, input logic md);
    if (ov && ie[2]) return 4'h6;
    if (rx && ie[0]) return 4'hC;
    if (th && ie[1]) return 4'h2;
    if (md && ie[3]) return 4'h0;
    return 4'h1;
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    logic [3:0] c1, c2;
    do_reset();
    #1;
    chk("R11 irq after reset", {7'b0, irq}, 8'h00);
    do_read(3'd1, r); chk("R11 IER after reset", r, 8'h00);
    do_read(3'd2, r); chk("R11 IIR after reset", r, 8'h01);
    do_read(3'd3, r); chk("R11 unowned offset", r, 8'hFF);
    do_read(3'd5, r); chk("R11 LSR after reset", r, 8'h60);

    for (int v = 0; v < 256; v++) begin
      logic [3:0] ie;
      logic ov, rx, th, md, fe;
      ie = v[3:0]; ov = v[4]; rx = v[5]; th = v[6]; md = v[7]; fe = v[0] ^ v[5];
      do_reset();
      rx_avail = 0; modem_delta = 0; fifo_en = fe;
      if (th) do_write(3'd0, 8'h5A);
      if (ov) pulse_ovr();
      do_write(3'd1, {~ie, ie});
      @(negedge clk); rx_avail = rx; modem_delta = md;
      #1;
      c1 = exp_code(ie, ov, rx, th, md);
      chk("R8 irq", {7'b0, irq}, {7'b0, c1 != 4'h1});
      do_read(3'd1, r); chk("R3 IER readback", r, {4'h0, ie});
      do_read(3'd2, r); chk("R1 R2 R6 IIR", r, {{2{fe}}, 2'b00, c1});
      c2 = exp_code(ie, ov, rx, th && (c1 != 4'h2), md);
      do_read(3'd2, r); chk("R5 IIR after first read", r, {{2{fe}}, 2'b00, c2});
      do_read(3'd5, r); chk("R7 LSR", r, {1'b0, 2'b11, 3'b000, ov, rx});
      do_read(3'd5, r); chk("R7 LSR overrun cleared", r, {1'b0, 2'b11, 3'b000, 1'b0, rx});
    end

    do_reset();
    rx_avail = 0; modem_delta = 0; fifo_en = 0;
    do_write(3'd1, 8'h0F);
    pulse_ovr();
    do_write(3'd5, 8'h00);
    do_write(3'd2, 8'h00);
    do_read(3'd1, r); chk("R9 IER after writes to read-only offsets", r, 8'h0F);
    do_read(3'd2, r); chk("R9 IIR still line status", r, 8'h06);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = 3'd5; ovr_set = 1;
    #1 chk("R10 LSR read with pulse", acc_rdata, 8'h62);
    @(negedge clk); acc_valid = 0; ovr_set = 0;
    do_read(3'd5, r); chk("R10 overrun kept set", r, 8'h62);
    do_read(3'd5, r); chk("R7 overrun then cleared", r, 8'h60);
    do_write(3'd0, 8'h00);
    do_read(3'd2, r); chk("R4 data write sets transmit-empty", r, 8'h02);
    #1 chk("R5 irq dropped after IIR read", {7'b0, irq}, 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule